// File: doc/BRIEF.md
# Peripheral Clock and Reset State Controller

This block sits next to one peripheral and drives that peripheral's local reset and clock-gate enable. Software writes a 3-bit mode code and pulses a go strobe. From then on the block holds the peripheral in one of six modes:

- Four fixed modes, which are the combinations of reset held or released with the clock running or stopped.
- Auto-sleep, an automatic mode that starts the clock for each bus access and stops it again when the bus goes quiet.
- Auto-wake, an automatic mode that starts the clock on the first bus access and keeps it running from then on.

The peripheral's slave port raises an access request. The block answers with a ready signal, which stays low until the gated clock is running. The requester therefore waits through the wake-up delay. A status field reports the mode in effect. Once an auto-wake module has woken up, the status field shows it as the plain running mode.

The clock enable and reset are decoded only from flip-flop outputs. They change only just after a clock edge, so the downstream clock gate never sees a shortened pulse. The wake-up delay and the idle gap before auto-sleep stops the clock are both parameters.

Top module: `pclk_rst_ctrl`

## Requirements
- R1: While `rst` is high and right after it, `mod_rst_o`=1, `clk_en_o`=0, `acc_rdy_o`=0 and `cur_state_o`=0 (reset held, clock stopped).
- R2: Mode codes are 0 = reset held with clock stopped, 1 = reset held with clock running, 2 = reset released with clock stopped, 3 = reset released with clock running, 4 = auto-sleep, 5 = auto-wake. `mod_rst_o` is high exactly in codes 0 and 1.
- R3: `clk_en_o` is high in codes 1 and 3 and low in codes 0 and 2. A go strobe sampled at an edge takes effect on the outputs just after that edge.
- R4: A go strobe carrying code 6 or 7 leaves the mode unchanged. Without a go strobe, `state_code_i` has no effect.
- R5: `acc_rdy_o` is high only while `clk_en_o` is high, so a request waits while the clock is stopped.
- R6: In code 4 or 5 while asleep, a request sampled at edge E0 starts a wake-up. `acc_rdy_o` stays low for `WAKE_LAT` cycles (default 4) after E0 and rises just after edge E0+`WAKE_LAT`.
- R7: In code 4 while awake, `clk_en_o` falls just after the `IDLE_GAP`-th consecutive edge (default 2) at which no request is sampled. A request that arrives inside that window sees `acc_rdy_o` already high and restarts the window.
- R8: In code 5, the clock stays on once awake, whether or not requests arrive. `cur_state_o` reads 5 before the wake-up and 3 after it.
- R9: In every mode other than a woken auto-wake, `cur_state_o` equals the code in effect. This includes code 4, whether asleep or awake.
- R10: A go strobe with a valid code always leaves the wake-up sequencer asleep, even if it writes the same auto code again. A request sampled at the same edge as the go strobe does not start a wake-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| go_i | input | 1 | Strobe that applies `state_code_i` |
| state_code_i | input | 3 | Requested mode code |
| acc_req_i | input | 1 | Bus access request from the peripheral's slave port |
| mod_rst_o | output | 1 | Peripheral local reset, active high |
| clk_en_o | output | 1 | Enable for the peripheral's clock gate |
| acc_rdy_o | output | 1 | Access may proceed; low holds the requester |
| cur_state_o | output | 3 | Mode code currently in effect |

## Verification
The checker assumes the bus follows a request/ready protocol: once raised, a request stays high until the edge at which ready is also high, and that edge completes the access. The idle-gap and wake-up properties only hold under that rule. The random requester in the bench therefore never drops a pending request while ready is low, and it raises new requests freely otherwise. The go strobe and its code, including the reserved codes, are randomized without constraint, because the block must tolerate any mode write at any cycle.

// File: rtl/pcr_pkg.sv
package pcr_pkg;

    typedef enum logic [2:0] {
        MS_RST_STOP   = 3'd0,
        MS_RST_RUN    = 3'd1,
        MS_STOPPED    = 3'd2,
        MS_RUNNING    = 3'd3,
        MS_AUTO_SLEEP = 3'd4,
        MS_AUTO_WAKE  = 3'd5
    } mstate_e;

    typedef enum logic [1:0] {
        PH_ASLEEP = 2'd0,
        PH_WAKING = 2'd1,
        PH_AWAKE  = 2'd2
    } phase_e;

    typedef struct packed {
        logic    mod_rst;
        logic    clk_en;
        mstate_e status;
    } ctl_out_t;

    function automatic logic code_valid(input logic [2:0] c);
        return c <= 3'd5;
    endfunction

    function automatic logic is_auto(input mstate_e s);
        return (s == MS_AUTO_SLEEP) || (s == MS_AUTO_WAKE);
    endfunction

    function automatic logic holds_reset(input mstate_e s);
        return (s == MS_RST_STOP) || (s == MS_RST_RUN);
    endfunction

    function automatic logic fixed_clock_on(input mstate_e s);
        return (s == MS_RST_RUN) || (s == MS_RUNNING);
    endfunction

endpackage

// File: rtl/pcr_prog_reg.sv
module pcr_prog_reg
    import pcr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       go_i,
    input  logic [2:0] code_i,
    output logic       load_o,
    output mstate_e    prog_o
);

    mstate_e prog_q;

    // A write is accepted only for codes 0..5; 6 and 7 are dropped
    assign load_o = go_i && code_valid(code_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            prog_q <= MS_RST_STOP;
        end else if (load_o) begin
            prog_q <= mstate_e'(code_i);
        end
    end

    assign prog_o = prog_q;

endmodule

// File: rtl/pcr_wake_seq.sv
module pcr_wake_seq
    import pcr_pkg::*;
#(
    parameter int WAKE_LAT = 4,
    parameter int IDLE_GAP = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    restart_i,
    input  mstate_e prog_i,
    input  logic    acc_req_i,
    output phase_e  phase_o
);

    localparam int CMAX = (WAKE_LAT > IDLE_GAP) ? WAKE_LAT : IDLE_GAP;
    localparam int CW   = (CMAX > 1) ? $clog2(CMAX + 1) : 1;
    localparam logic [CW-1:0] WAKE_END = CW'(WAKE_LAT - 1);
    localparam logic [CW-1:0] IDLE_END = CW'(IDLE_GAP - 1);

    phase_e        ph_q;
    logic [CW-1:0] cnt_q;
    logic          sleep_ok;

    // Only auto-sleep drops the clock again once awake
    assign sleep_ok = (prog_i == MS_AUTO_SLEEP);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_ASLEEP;
            cnt_q <= '0;
        end else if (restart_i || !is_auto(prog_i)) begin
            ph_q  <= PH_ASLEEP;
            cnt_q <= '0;
        end else begin
            unique case (ph_q)
                PH_ASLEEP: begin
                    cnt_q <= '0;
                    if (acc_req_i) ph_q <= PH_WAKING;
                end
                PH_WAKING: begin
                    if (cnt_q == WAKE_END) begin
                        ph_q  <= PH_AWAKE;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + CW'(1);
                    end
                end
                PH_AWAKE: begin
                    if (sleep_ok) begin
                        if (acc_req_i) begin
                            cnt_q <= '0;
                        end else if (cnt_q == IDLE_END) begin
                            ph_q  <= PH_ASLEEP;
                            cnt_q <= '0;
                        end else begin
                            cnt_q <= cnt_q + CW'(1);
                        end
                    end
                end
                default: begin
                    ph_q  <= PH_ASLEEP;
                    cnt_q <= '0;
                end
            endcase
        end
    end

    assign phase_o = ph_q;

endmodule

// File: rtl/pcr_out_map.sv
module pcr_out_map
    import pcr_pkg::*;
(
    input  mstate_e  prog_i,
    input  phase_e   phase_i,
    output ctl_out_t ctl_o
);

    logic auto_on;

    assign auto_on = is_auto(prog_i) && (phase_i == PH_AWAKE);

    // Pure decode of flop outputs: every change follows a clock edge
    always_comb begin
        ctl_o.mod_rst = holds_reset(prog_i);
        ctl_o.clk_en  = fixed_clock_on(prog_i) || auto_on;
        ctl_o.status  = (prog_i == MS_AUTO_WAKE && auto_on) ? MS_RUNNING : prog_i;
    end

endmodule

// File: rtl/pclk_rst_ctrl.sv
module pclk_rst_ctrl
    import pcr_pkg::*;
#(
    parameter int WAKE_LAT = 4,
    parameter int IDLE_GAP = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go_i,
    input  logic [2:0] state_code_i,
    input  logic       acc_req_i,
    output logic       mod_rst_o,
    output logic       clk_en_o,
    output logic       acc_rdy_o,
    output logic [2:0] cur_state_o
);

    logic     load;
    mstate_e  prog_q;
    phase_e   phase_q;
    ctl_out_t ctl;

    pcr_prog_reg u_prog (
        .clk    (clk),
        .rst    (rst),
        .go_i   (go_i),
        .code_i (state_code_i),
        .load_o (load),
        .prog_o (prog_q)
    );

    pcr_wake_seq #(
        .WAKE_LAT (WAKE_LAT),
        .IDLE_GAP (IDLE_GAP)
    ) u_wake (
        .clk       (clk),
        .rst       (rst),
        .restart_i (load),
        .prog_i    (prog_q),
        .acc_req_i (acc_req_i),
        .phase_o   (phase_q)
    );

    pcr_out_map u_map (
        .prog_i  (prog_q),
        .phase_i (phase_q),
        .ctl_o   (ctl)
    );

    assign mod_rst_o   = ctl.mod_rst;
    assign clk_en_o    = ctl.clk_en;
    assign acc_rdy_o   = ctl.clk_en;
    assign cur_state_o = ctl.status;

endmodule

// File: rtl/pclk_rst_ctrl_chk.sv
module pclk_rst_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       go_i,
    input logic [2:0] state_code_i,
    input logic       acc_req_i,
    input logic       mod_rst_o,
    input logic       clk_en_o,
    input logic       acc_rdy_o,
    input logic [2:0] cur_state_o,
    input logic [2:0] prog_q,
    input logic [1:0] phase_q
);

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (mod_rst_o && !clk_en_o && !acc_rdy_o && cur_state_o == 3'd0));

    a_r2_reset_codes: assert property (@(posedge clk) disable iff (rst)
        mod_rst_o == (cur_state_o <= 3'd1));

    a_r3_running_has_clock: assert property (@(posedge clk) disable iff (rst)
        (cur_state_o == 3'd3) |-> clk_en_o);

    a_r4_reserved_ignored: assert property (@(posedge clk) disable iff (rst)
        (go_i && state_code_i > 3'd5) |=> (prog_q == $past(prog_q)));

    a_r6_no_instant_ready: assert property (@(posedge clk) disable iff (rst)
        ((prog_q == 3'd4 || prog_q == 3'd5) && phase_q == 2'd0 && !go_i) |=> !acc_rdy_o);

    a_r7_gap_before_stop: assert property (@(posedge clk) disable iff (rst)
        (prog_q == 3'd4 && $fell(clk_en_o) && !$past(go_i))
            |-> (!$past(acc_req_i) && !$past(acc_req_i, 2)));

    a_r8_awake_stays_on: assert property (@(posedge clk) disable iff (rst)
        (prog_q == 3'd5 && clk_en_o && !go_i) |=> clk_en_o);

endmodule

bind pclk_rst_ctrl pclk_rst_ctrl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .go_i         (go_i),
    .state_code_i (state_code_i),
    .acc_req_i    (acc_req_i),
    .mod_rst_o    (mod_rst_o),
    .clk_en_o     (clk_en_o),
    .acc_rdy_o    (acc_rdy_o),
    .cur_state_o  (cur_state_o),
    .prog_q       (prog_q),
    .phase_q      (phase_q)
);

// File: tb/pclk_rst_ctrl_bench.sv
module pclk_rst_ctrl_bench;

    localparam int LAT = 4;
    localparam int GAP = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       go = 1'b0;
    logic [2:0] code = 3'd0;
    logic       acc_req = 1'b0;
    logic       mod_rst, clk_en, acc_rdy;
    logic [2:0] cur_state;

    int total = 0;
    int bad = 0;
    bit done = 0;
    int m_prog = 0, m_ph = 0, m_cnt = 0;

    always #10 clk = ~clk;

    pclk_rst_ctrl #(.WAKE_LAT(LAT), .IDLE_GAP(GAP)) u_pclk_rst_ctrl (
        .clk          (clk),
        .rst          (rst),
        .go_i         (go),
        .state_code_i (code),
        .acc_req_i    (acc_req),
        .mod_rst_o    (mod_rst),
        .clk_en_o     (clk_en),
        .acc_rdy_o    (acc_rdy),
        .cur_state_o  (cur_state)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference model built from the requirement text
    function automatic void model_step(input bit g, input int c, input bit r);
        if (g && c <= 5) begin
            m_prog = c; m_ph = 0; m_cnt = 0;           // R10
        end else if (m_prog < 4) begin
            m_ph = 0; m_cnt = 0;
        end else begin
            case (m_ph)
                0: if (r) begin m_ph = 1; m_cnt = 0; end
                1: if (m_cnt == LAT - 1) begin m_ph = 2; m_cnt = 0; end
                   else m_cnt++;
                default: if (m_prog == 4) begin
                    if (r) m_cnt = 0;
                    else if (m_cnt == GAP - 1) begin m_ph = 0; m_cnt = 0; end
                    else m_cnt++;
                end
            endcase
        end
    endfunction

    function automatic int e_clk();
        return (m_prog == 1 || m_prog == 3 || (m_prog >= 4 && m_ph == 2)) ? 1 : 0;
    endfunction

    function automatic int e_state();
        return (m_prog == 5 && m_ph == 2) ? 3 : m_prog;
    endfunction

    task automatic compare_all();
        chk("R2 mod_rst", int'(mod_rst), (m_prog < 2) ? 1 : 0);
        chk("R3 clk_en", int'(clk_en), e_clk());
        chk("R5 acc_rdy", int'(acc_rdy), e_clk());
        chk("R9 cur_state", int'(cur_state), e_state());
    endtask

    task automatic tick(input bit g, input int c, input bit r);
        go = g; code = 3'(c); acc_req = r;
        @(posedge clk);
        model_step(g, c, r);
        @(negedge clk);
        compare_all();
    endtask

    // Holds a request from the sampling edge until ready; returns low cycles
    task automatic wake_count(output int n);
        n = 0;
        tick(0, 0, 1);
        while (!acc_rdy && n < 20) begin
            n++;
            tick(0, 0, 1);
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        void'($urandom(32'h1A2B3C4D));
        repeat (3) @(negedge clk);
        chk("R1 mod_rst", int'(mod_rst), 1);
        chk("R1 clk_en", int'(clk_en), 0);
        chk("R1 acc_rdy", int'(acc_rdy), 0);
        chk("R1 cur_state", int'(cur_state), 0);
        rst = 1'b0;

        tick(1, 3, 0);
        chk("R3 running clk", int'(clk_en), 1);
        tick(1, 2, 0);
        chk("R3 stopped clk", int'(clk_en), 0);
        chk("R2 stopped rst", int'(mod_rst), 0);
        tick(1, 1, 0);
        chk("R2 rst-run rst", int'(mod_rst), 1);
        tick(1, 6, 0);
        chk("R4 code 6", int'(cur_state), 1);
        tick(1, 7, 0);
        chk("R4 code 7", int'(cur_state), 1);
        tick(0, 3, 0);
        chk("R4 no go", int'(cur_state), 1);

        // Auto-sleep wake latency and idle gap
        tick(1, 4, 0);
        chk("R6 asleep", int'(clk_en), 0);
        wake_count(n);
        chk("R6 wake cycles", n, LAT);
        tick(0, 0, 1);                     // access completes here
        tick(0, 0, 0);
        chk("R7 still on", int'(clk_en), 1);
        tick(0, 0, 0);
        chk("R7 stopped", int'(clk_en), 0);
        chk("R9 auto-sleep status", int'(cur_state), 4);
        wake_count(n);
        tick(0, 0, 1);
        tick(0, 0, 0);
        chk("R7 window ready", int'(acc_rdy), 1);
        tick(0, 0, 1);                     // served without a wake-up
        tick(0, 0, 0);
        chk("R7 window restart", int'(clk_en), 1);
        tick(0, 0, 0);
        chk("R7 stop after window", int'(clk_en), 0);

        // Auto-wake
        tick(1, 5, 0);
        chk("R8 before wake status", int'(cur_state), 5);
        wake_count(n);
        chk("R8 wake cycles", n, LAT);
        chk("R8 status running", int'(cur_state), 3);
        repeat (10) tick(0, 0, 0);
        chk("R8 stays on", int'(clk_en), 1);
        tick(1, 5, 1);
        chk("R10 rewrite sleeps", int'(clk_en), 0);
        tick(0, 0, 0);
        chk("R10 go beats request", int'(clk_en), 0);

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            bit g, r;
            int c;
            g = ($urandom % 100) < 4;
            c = $urandom % 8;
            if (acc_req && !acc_rdy) r = 1;
            else r = ($urandom % 100) < 30;
            tick(g, c, r);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule